// File: doc/BRIEF.md
# Constant On-Time Buck Switch Sequencer

This block is the digital heart of a synchronous step-down converter run under constant on-time control. Analog comparators outside the block report four conditions as single-bit flags: feedback has sagged below the regulation reference, feedback has climbed above the over-voltage reference, the synchronous (low-side) switch current is above its limit, and the inductor current has reached zero. A separate calculation supplies the desired on-time as a clock-cycle count. From these the block drives the enables of the high-side and low-side gate drivers.

A switching cycle begins only when feedback sags. The high-side switch then conducts for the programmed count, which is never allowed to fall below a fixed minimum. A break-before-make gap follows, then the low-side switch conducts. The next pulse cannot begin until a minimum off interval has passed. Over-voltage cuts a pulse short. An over-limit current seen while the low side conducts holds off the next pulse. A zero-current flag opens the low-side switch so the stage runs in discontinuous mode at light load. Dropping the run enable parks the block with both switches open.

Minimum times are given in picoseconds together with the clock period, and the block converts them to cycle counts. At the default 4 ns clock the minimum on-time is 38 cycles and the minimum off-time is 65 cycles.

Top module: `cot_buck_seq`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `hs_gate` and `ls_gate` are both 0.
- R2: A high-side pulse starts only after `fb_under` has been sampled 1. While `fb_under` stays 0, `hs_gate` never rises.
- R3: When `on_cycles` is at least the minimum on-time (38 cycles by default), `hs_gate` stays high for exactly `on_cycles` clock cycles.
- R4: When `on_cycles` is below the minimum, including 0, the pulse lasts exactly the minimum on-time.
- R5: The on-time count is captured in the cycle a pulse starts. Changing `on_cycles` during that pulse does not change its length.
- R6: Between two pulses `hs_gate` stays low for at least the minimum off-time (65 cycles by default). If `fb_under` is held at 1 and no other flag is active, the gap is exactly the minimum off-time plus the dead time.
- R7: If `fb_over` is sampled 1 while `hs_gate` is high, `hs_gate` is 0 after the next clock edge. No new pulse starts while `fb_over` stays 1, and pulses resume once it clears.
- R8: While `fb_over` is 1, `ls_gate` stays high until `il_zero` is sampled 1.
- R9: `isw_over` is looked at only while `ls_gate` is high. While it is 1 there, no pulse starts. When it clears with `fb_under` at 1 and the off-time met, `hs_gate` rises after exactly dead+1 edges. `isw_over` has no effect while both switches are open.
- R10: When `il_zero` is sampled 1 while `ls_gate` is high, `ls_gate` falls at the next edge and stays low until after the next high-side pulse.
- R11: `hs_gate` and `ls_gate` are never 1 together. Every hand-over between them has exactly `dead_cycles` cycles with both at 0, where a value of 0 is treated as 1.
- R12: When `run_en` is sampled 0, both gates are 0 after the next edge and the block idles. After `run_en` returns to 1 with `fb_under` at 1 and the off-time met, `hs_gate` rises after exactly 2 + dead edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Synchronous reset, active low |
| run_en | input | 1 | Run enable; low forces both switches open and clears any pending state |
| fb_under | input | 1 | Feedback below regulation reference |
| fb_over | input | 1 | Feedback above over-voltage reference |
| isw_over | input | 1 | Low-side switch current above limit |
| il_zero | input | 1 | Inductor current has reached zero |
| on_cycles | input | ON_W | Programmed on-time in clock cycles |
| dead_cycles | input | DT_W | Break-before-make gap in clock cycles (0 treated as 1) |
| hs_gate | output | 1 | High-side switch enable |
| ls_gate | output | 1 | Low-side switch enable |

## Verification
A corrupted sequencer state shows at the gate pins at the next clock edge. Both enables are registered from the next-state decode, so an illegal state appears either as a missing dead-time cycle or as a pulse whose length differs from the captured count by at least one cycle. Faults in the timers are subtler: they leave the gate pattern legal but change pulse width, off gap or hand-over spacing. For that reason the pulse lengths, gaps and restart delays are checked as exact cycle counts, not just bounds.

// File: rtl/cot_pkg.sv
// Shared types and helpers for the constant on-time sequencer.
// Assumes: all time parameters are positive integers in picoseconds.
package cot_pkg;

    // Sequencer phases; each maps to one gate pattern.
    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,   // disabled, both switches open
        PH_WAIT = 3'd1,   // enabled, both open (start-up or discontinuous gap)
        PH_RISE = 3'd2,   // dead time before the high side closes
        PH_HIGH = 3'd3,   // high side conducting
        PH_FALL = 3'd4,   // dead time before the low side closes
        PH_LOW  = 3'd5    // low side conducting
    } cot_phase_e;

    // Integer ceiling division used to turn times into cycle counts.
    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

endpackage

// File: rtl/cot_span_timer.sv
// Down-counting span timer. A load pulse starts a span of load_val cycles,
// counting the first cycle after the load; done is high in the last cycle.
// Assumes: load_val >= 1 whenever load is asserted.
module cot_span_timer #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);

    logic [W-1:0] remain_q;

    // Capture the span on load, otherwise count down to zero and hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain_q <= '0;
        end else if (load) begin
            remain_q <= load_val - W'(1);
        end else if (remain_q != '0) begin
            remain_q <= remain_q - W'(1);
        end
    end

    assign done = (remain_q == '0);

endmodule

// File: rtl/cot_off_timer.sv
// Minimum off-time guard. Restarted when the high-side pulse ends; reports
// done once enough cycles have elapsed for a new pulse request to be legal.
// Assumes: LIMIT is the minimum off-time in cycles; reset leaves it expired
// so the first pulse after reset is not delayed.
module cot_off_timer #(
    parameter int LIMIT = 65
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic done
);

    generate
        if (LIMIT <= 1) begin : g_trivial
            // No off-time to enforce beyond a single cycle.
            assign done = 1'b1;
        end else begin : g_count
            localparam int CW = $clog2(LIMIT + 1);
            localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);
            logic [CW-1:0] elapsed_q;

            // Count cycles since the high side opened, saturating at LAST.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    elapsed_q <= LAST;
                end else if (restart) begin
                    elapsed_q <= '0;
                end else if (elapsed_q != LAST) begin
                    elapsed_q <= elapsed_q + CW'(1);
                end
            end

            assign done = (elapsed_q == LAST);
        end
    endgenerate

endmodule

// File: rtl/cot_seq_fsm.sv
// Phase sequencer for the constant on-time buck stage. Decides when pulses
// start and end, inserts dead time around every hand-over, and registers
// the gate enables from the next phase so they are glitch-free.
// Assumes: timer done inputs come from cot_span_timer / cot_off_timer and
// refer to the loads this module issued.
module cot_seq_fsm
    import cot_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run_en,
    input  logic fb_under,
    input  logic fb_over,
    input  logic isw_over,
    input  logic il_zero,
    input  logic on_done,
    input  logic dead_done,
    input  logic off_done,
    output logic on_load,
    output logic dead_load,
    output logic off_restart,
    output logic hs_gate,
    output logic ls_gate
);

    cot_phase_e phase_q, phase_d;
    logic       start_ok;

    // Common pulse-start condition shared by the open and low-side phases.
    always_comb begin
        start_ok = fb_under && !fb_over && off_done;
    end

    // Next-phase decode and timer load strobes.
    always_comb begin
        phase_d   = phase_q;
        on_load   = 1'b0;
        dead_load = 1'b0;
        if (!run_en) begin
            phase_d = PH_IDLE;
        end else begin
            unique case (phase_q)
                PH_IDLE: begin
                    phase_d = PH_WAIT;
                end
                PH_WAIT: begin
                    if (start_ok) begin
                        phase_d   = PH_RISE;
                        dead_load = 1'b1;
                    end
                end
                PH_LOW: begin
                    if (start_ok && !isw_over) begin
                        phase_d   = PH_RISE;
                        dead_load = 1'b1;
                    end else if (il_zero) begin
                        phase_d = PH_WAIT;
                    end
                end
                PH_RISE: begin
                    if (fb_over) begin
                        phase_d   = PH_FALL;
                        dead_load = 1'b1;
                    end else if (dead_done) begin
                        phase_d = PH_HIGH;
                        on_load = 1'b1;
                    end
                end
                PH_HIGH: begin
                    if (fb_over || on_done) begin
                        phase_d   = PH_FALL;
                        dead_load = 1'b1;
                    end
                end
                PH_FALL: begin
                    if (dead_done) begin
                        phase_d = PH_LOW;
                    end
                end
                default: begin
                    phase_d = PH_IDLE;
                end
            endcase
        end
    end

    // Any exit from the conducting high phase starts the off-time guard.
    always_comb begin
        off_restart = (phase_q == PH_HIGH) && (phase_d != PH_HIGH);
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
        end else begin
            phase_q <= phase_d;
        end
    end

    // Gate enables registered from the next phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_gate <= 1'b0;
            ls_gate <= 1'b0;
        end else begin
            hs_gate <= (phase_d == PH_HIGH);
            ls_gate <= (phase_d == PH_LOW);
        end
    end

    AST_EN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> (!hs_gate && !ls_gate)); // R12

    AST_OVP_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_gate && fb_over) |=> !hs_gate); // R7

    AST_LS_HOLD_OVP: assert property (@(posedge clk) disable iff (!rst_n)
        (ls_gate && fb_over && !il_zero && run_en) |=> ls_gate); // R8

    AST_ZERO_OPENS_LS: assert property (@(posedge clk) disable iff (!rst_n)
        (ls_gate && il_zero) |=> !ls_gate); // R10

    AST_GAP_BEFORE_HS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_gate) |-> !$past(ls_gate)); // R11

    AST_GAP_BEFORE_LS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ls_gate) |-> !$past(hs_gate)); // R11

endmodule

// File: rtl/cot_buck_seq.sv
// Constant on-time buck switch sequencer, top level. Converts the time
// parameters into cycle counts, clamps the programmed on-time and dead
// time, and wires the phase sequencer to its three timers.
// Assumes: comparator flags are already synchronous to clk.
module cot_buck_seq
    import cot_pkg::*;
#(
    parameter int CLK_PS      = 4000,
    parameter int MIN_ON_PS   = 150000,
    parameter int MIN_OFF_PS  = 260000,
    parameter int ON_W        = 10,
    parameter int DT_W        = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run_en,
    input  logic            fb_under,
    input  logic            fb_over,
    input  logic            isw_over,
    input  logic            il_zero,
    input  logic [ON_W-1:0] on_cycles,
    input  logic [DT_W-1:0] dead_cycles,
    output logic            hs_gate,
    output logic            ls_gate
);

    localparam int MIN_ON_CYC  = ceil_div(MIN_ON_PS, CLK_PS);
    localparam int MIN_OFF_CYC = ceil_div(MIN_OFF_PS, CLK_PS);
    localparam logic [ON_W-1:0] MIN_ON_V = ON_W'(MIN_ON_CYC);

    logic            on_load, dead_load, off_restart;
    logic            on_done, dead_done, off_done;
    logic [ON_W-1:0] on_len;
    logic [DT_W-1:0] dead_len;

    // Clamp the requested on-time to the minimum pulse width.
    always_comb begin
        on_len = (on_cycles < MIN_ON_V) ? MIN_ON_V : on_cycles;
    end

    // Dead time of zero would merge a hand-over; force at least one cycle.
    always_comb begin
        dead_len = (dead_cycles == '0) ? DT_W'(1) : dead_cycles;
    end

    cot_seq_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_en      (run_en),
        .fb_under    (fb_under),
        .fb_over     (fb_over),
        .isw_over    (isw_over),
        .il_zero     (il_zero),
        .on_done     (on_done),
        .dead_done   (dead_done),
        .off_done    (off_done),
        .on_load     (on_load),
        .dead_load   (dead_load),
        .off_restart (off_restart),
        .hs_gate     (hs_gate),
        .ls_gate     (ls_gate)
    );

    cot_span_timer #(.W(ON_W)) u_on_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (on_load),
        .load_val (on_len),
        .done     (on_done)
    );

    cot_span_timer #(.W(DT_W)) u_dead_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (dead_load),
        .load_val (dead_len),
        .done     (dead_done)
    );

    cot_off_timer #(.LIMIT(MIN_OFF_CYC)) u_off_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (off_restart),
        .done    (off_done)
    );

    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_gate && ls_gate)); // R11

    AST_START_NEEDS_FB: assert property (@(posedge clk) disable iff (!rst_n)
        (!hs_gate && !ls_gate && run_en && !fb_under) |=> !hs_gate); // R2

endmodule

// File: tb/cot_buck_seq_tb.sv
// Directed bench for cot_buck_seq: one task per scenario, each self-checking.
module cot_buck_seq_tb;

    localparam int MIN_ON  = 38;   // 150 ns at 4 ns, rounded up
    localparam int MIN_OFF = 65;   // 260 ns at 4 ns

    logic       clk = 1'b0;
    logic       rst_n, run_en, fb_under, fb_over, isw_over, il_zero;
    logic [9:0] on_cycles;
    logic [2:0] dead_cycles;
    logic       hs_gate, ls_gate;

    always #2 clk = ~clk;

    cot_buck_seq u_dut (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .fb_under(fb_under),
        .fb_over(fb_over), .isw_over(isw_over), .il_zero(il_zero),
        .on_cycles(on_cycles), .dead_cycles(dead_cycles),
        .hs_gate(hs_gate), .ls_gate(ls_gate)
    );

    int n_chk = 0;
    int n_bad = 0;
    int n_overlap = 0;
    bit finished = 0;
    logic prev_hs = 1'b0, prev_ls = 1'b0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Overlap and direct hand-over monitor (R11).
    always @(negedge clk) begin
        if (rst_n) begin
            if (hs_gate && ls_gate) n_overlap++;
            if ((hs_gate && prev_ls) || (ls_gate && prev_hs)) n_overlap++;
            prev_hs <= hs_gate;
            prev_ls <= ls_gate;
        end
    end

    task automatic wait_hs(input int limit, output int n);
        n = 0;
        while (!hs_gate && n < limit) begin @(negedge clk); n++; end
    endtask

    task automatic wait_ls(input int limit, output int n);
        n = 0;
        while (!ls_gate && n < limit) begin @(negedge clk); n++; end
    endtask

    // Waits for a pulse and returns its width; optional mid-pulse actions.
    task automatic pulse(input bit drop_fb, input int chg_at, input logic [9:0] chg_val,
                         input int ovp_at, output int w);
        int n;
        wait_hs(1000, n);
        w = 0;
        while (hs_gate && w < 2000) begin
            w++;
            if (w == 1 && drop_fb) fb_under = 1'b0;
            if (w == chg_at) on_cycles = chg_val;
            if (w == ovp_at) fb_over = 1'b1;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        int seen = 0;
        rst_n = 1'b0; run_en = 1'b1; fb_under = 1'b1; fb_over = 1'b0;
        isw_over = 1'b0; il_zero = 1'b0; on_cycles = 10'd50; dead_cycles = 3'd2;
        repeat (4) @(negedge clk);
        check(!hs_gate && !ls_gate, "R1 gates during reset", {hs_gate, ls_gate}, 0);
        fb_under = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check(!hs_gate && !ls_gate, "R1 gates after release", {hs_gate, ls_gate}, 0);
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (hs_gate) seen++;
        end
        check(seen == 0, "R2 no pulse without fb_under", seen, 0);
    endtask

    task automatic t_basic();
        int w, g, lr;
        fb_under = 1'b1;
        pulse(1'b0, -1, 10'd0, -1, w);
        check(w == 50, "R3 pulse width", w, 50);
        g = 0;
        while (!ls_gate && g < 20) begin g++; @(negedge clk); end
        check(g == 2, "R11 dead gap high to low", g, 2);
        lr = g;
        while (!hs_gate && lr < 500) begin lr++; @(negedge clk); end
        check(lr == MIN_OFF + 2, "R6 off gap with fb held", lr, MIN_OFF + 2);
        pulse(1'b1, -1, 10'd0, -1, w);
        check(w == 50, "R3 second pulse width", w, 50);
    endtask

    task automatic t_clamp();
        int w;
        on_cycles = 10'd10; fb_under = 1'b1;
        pulse(1'b1, -1, 10'd0, -1, w);
        check(w == MIN_ON, "R4 short count clamped", w, MIN_ON);
        on_cycles = 10'd0; fb_under = 1'b1;
        pulse(1'b1, -1, 10'd0, -1, w);
        check(w == MIN_ON, "R4 zero count clamped", w, MIN_ON);
    endtask

    task automatic t_capture();
        int w;
        on_cycles = 10'd60; fb_under = 1'b1;
        pulse(1'b1, 5, 10'd100, -1, w);
        check(w == 60, "R5 mid-pulse change ignored", w, 60);
        fb_under = 1'b1;
        pulse(1'b1, -1, 10'd0, -1, w);
        check(w == 100, "R5 new count used next pulse", w, 100);
    endtask

    task automatic t_ovp();
        int w, n, seen = 0;
        on_cycles = 10'd100; fb_under = 1'b1;
        pulse(1'b0, -1, 10'd0, 10, w);
        check(w == 10, "R7 over-voltage cuts pulse", w, 10);
        for (int i = 0; i < 150; i++) begin
            @(negedge clk);
            if (hs_gate) seen++;
        end
        check(seen == 0, "R7 no pulse while over-voltage", seen, 0);
        check(ls_gate == 1'b1, "R8 low side held during over-voltage", ls_gate, 1);
        il_zero = 1'b1;
        @(negedge clk);
        check(ls_gate == 1'b0, "R8 low side opens on zero current", ls_gate, 0);
        il_zero = 1'b0; fb_over = 1'b0;
        wait_hs(20, n);
        check(hs_gate == 1'b1, "R7 pulses resume after clear", hs_gate, 1);
        pulse(1'b1, -1, 10'd0, -1, w);
    endtask

    task automatic t_ilim();
        int n, seen = 0;
        int w;
        wait_ls(50, n);
        isw_over = 1'b1; fb_under = 1'b1;
        for (int i = 0; i < 150; i++) begin
            @(negedge clk);
            if (hs_gate) seen++;
        end
        check(seen == 0, "R9 limit withholds pulse", seen, 0);
        check(ls_gate == 1'b1, "R9 low side still on", ls_gate, 1);
        isw_over = 1'b0;
        wait_hs(50, n);
        check(n == 3, "R9 restart delay after limit clears", n, 3);
        pulse(1'b1, -1, 10'd0, -1, w);
        wait_ls(50, n);
        il_zero = 1'b1;
        @(negedge clk);
        il_zero = 1'b0;
        isw_over = 1'b1; fb_under = 1'b1;
        wait_hs(300, n);
        check(hs_gate == 1'b1, "R9 limit ignored with switches open", hs_gate, 1);
        isw_over = 1'b0;
        pulse(1'b1, -1, 10'd0, -1, w);
    endtask

    task automatic t_dcm();
        int n, on_seen = 0;
        int w;
        wait_ls(50, n);
        il_zero = 1'b1;
        @(negedge clk);
        check(ls_gate == 1'b0, "R10 zero current opens low side", ls_gate, 0);
        il_zero = 1'b0;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (ls_gate || hs_gate) on_seen++;
        end
        check(on_seen == 0, "R10 low side stays open", on_seen, 0);
        fb_under = 1'b1;
        pulse(1'b1, -1, 10'd0, -1, w);
        wait_ls(10, n);
        check(n == 2, "R10 low side returns after pulse", n, 2);
    endtask

    task automatic t_enable();
        int n, seen = 0;
        int w;
        dead_cycles = 3'd3; on_cycles = 10'd80; fb_under = 1'b1;
        wait_hs(300, n);
        repeat (3) @(negedge clk);
        run_en = 1'b0;
        @(negedge clk);
        check(!hs_gate && !ls_gate, "R12 disable mid-pulse", {hs_gate, ls_gate}, 0);
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (hs_gate || ls_gate) seen++;
        end
        check(seen == 0, "R12 idle while disabled", seen, 0);
        run_en = 1'b1;
        wait_hs(50, n);
        check(n == 5, "R12 restart delay after enable", n, 5);
        pulse(1'b1, -1, 10'd0, -1, w);
        wait_ls(10, n);
        check(n == 3, "R11 dead gap of three", n, 3);
        run_en = 1'b0;
        @(negedge clk);
        check(ls_gate == 1'b0, "R12 disable opens low side", ls_gate, 0);
        run_en = 1'b1;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=complete");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_basic();
        t_clamp();
        t_capture();
        t_ovp();
        t_ilim();
        t_dcm();
        t_enable();
        repeat (5) @(negedge clk);
        check(n_overlap == 0, "R11 no overlap or direct hand-over", n_overlap, 0);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule